// File: doc/BRIEF.md
# One-Time-Writable Byte Memory with Programming Controller

This block models a byte-wide memory whose cells start erased (all ones) and can only have bits cleared by programming. In normal operation it behaves as a read-only store: an address and an active-low select put the chosen byte on the output, and an output-enable flag stands in for a three-state bus.

When the mode-enable input (the digital stand-in for the programming supply) is high and the select is low, the block enters its programming group. Several upper address pins then serve as control strobes rather than address bits. Because those pins are taken, the upper part of the address is loaded through the low address lines into an internal register. The strobes choose between program, verify, inhibit and blank-check operations. A strobe combination that is not allowed raises an error flag.

A synchronous erase input starts a sweep that returns every byte to all ones. A busy flag stays high while the sweep runs.

Top module: `eprom_prog_model`

## Requirements
- R1: With `hv_en` low and `cs_n` low (and no sweep running), `data_oe` is 1 and `data_out` holds the byte at `addr`.
- R2: With `hv_en` low and `cs_n` high, `data_oe` is 0 and `data_out` is 0. This is also the state after reset.
- R3: The programming group is active only while `hv_en` is high and `cs_n` is low. With `hv_en` high and `cs_n` high, nothing is driven and a program strobe writes nothing.
- R4: In the programming group, `addr[LO_W+2]` is the latch strobe, `addr[LO_W+1]` is the active-low program strobe, `addr[LO_W]` is the active-low verify strobe and `addr[ADDR_W-1]` selects blank check. While the latch strobe is high at a clock edge, `addr[HI_W-1:0]` is loaded as the upper address. Every programming-group access uses the upper address {latched, `addr[LO_W-1:0]`}.
- R5: A program strobe that falls while the verify strobe is high and blank check is not selected writes exactly once, at the next clock edge. Holding the strobe low does not write again.
- R6: With the program strobe high and the verify strobe low (blank check not selected), `data_oe` is 1 and `data_out` is the addressed byte.
- R7: With both strobes high, `data_oe` is 0. The same holds while the program strobe is low.
- R8: With both strobes low in the programming group, `strobe_err` is 1, `data_oe` is 0, and no write takes place.
- R9: With blank check selected, the program strobe high and the verify strobe low, `blank_ok` is 1 exactly when the addressed byte is all ones.
- R10: An `erase` pulse sets `busy` from the next edge for exactly 2^ADDR_W cycles and leaves every byte all ones. While `busy` is high, `data_oe` and `blank_ok` are 0 and no program write takes place.
- R11: A program operation stores the old byte ANDed with `data_in`, so it can only clear bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_en | input | 1 | Programming mode enable (high voltage present) |
| cs_n | input | 1 | Active-low chip select |
| addr | input | ADDR_W | Address, with upper pins used as strobes in programming |
| data_in | input | DATA_W | Byte to program |
| erase | input | 1 | Start a full-array erase sweep |
| data_out | output | DATA_W | Read or verify data, 0 when not driven |
| data_oe | output | 1 | Output driven flag |
| strobe_err | output | 1 | Both program and verify strobes low |
| blank_ok | output | 1 | Blank-check result: addressed byte erased |
| busy | output | 1 | Erase sweep in progress |

## Verification
The bench builds the block with ADDR_W = 12 and LO_W = 8. This gives a 4096-byte array with a four-bit latched upper field, so the strobe pins (bits 10, 9 and 8) and the blank-select pin (bit 11) are all distinct from the latched field. The smaller array makes two full erase sweeps affordable, and the exact length of the sweep is counted. The generic positions of the pins are exercised with a width that differs from the default.

// File: rtl/eprom_prog_model.sv
module eprom_prog_model #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_en,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              erase,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              strobe_err,
  output logic              blank_ok,
  output logic              busy
);
  localparam int HI_W    = ADDR_W - LO_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int LATCH_B = LO_W + 2;
  localparam int PGM_B   = LO_W + 1;
  localparam int VFY_B   = LO_W;
  localparam int SEL_B   = ADDR_W - 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] sweep_q;
  logic              pgm_lo_q;

  wire prog_grp  = hv_en & ~cs_n;
  wire blank_sel = addr[SEL_B];
  wire pgm_n     = addr[PGM_B];
  wire vfy_n     = addr[VFY_B];
  wire pgm_lo    = prog_grp & ~pgm_n;

  wire [ADDR_W-1:0] eff_addr = hv_en ? {hi_q, addr[LO_W-1:0]} : addr;
  wire [DATA_W-1:0] rd       = mem[eff_addr];

  wire do_wr  = pgm_lo & ~pgm_lo_q & vfy_n & ~blank_sel & ~busy;
  wire verify = prog_grp & ~blank_sel & pgm_n & ~vfy_n;

  assign strobe_err = prog_grp & ~pgm_n & ~vfy_n;
  assign blank_ok   = prog_grp & blank_sel & pgm_n & ~vfy_n & ~busy & (&rd);
  assign data_oe    = ~busy & ((~hv_en & ~cs_n) | verify);
  assign data_out   = data_oe ? rd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      pgm_lo_q <= 1'b0;
      busy     <= 1'b0;
      sweep_q  <= '0;
    end else begin
      pgm_lo_q <= pgm_lo;
      if (prog_grp && addr[LATCH_B] && !busy)
        hi_q <= addr[HI_W-1:0];
      if (busy) begin
        sweep_q <= sweep_q + 1'b1;
        if (sweep_q == ADDR_W'(DEPTH - 1))
          busy <= 1'b0;
      end else if (erase) begin
        busy    <= 1'b1;
        sweep_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy)
      mem[sweep_q] <= '1;
    else if (do_wr)
      mem[eff_addr] <= rd & data_in;
  end
endmodule

// File: rtl/eprom_prog_model_chk.sv
module eprom_prog_model_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hv_en,
  input logic              cs_n,
  input logic              erase,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe,
  input logic              strobe_err,
  input logic              blank_ok,
  input logic              busy
);
  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hv_en && cs_n) |-> !data_oe);
  assert_hv_deselect_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_en && cs_n) |-> (!data_oe && !strobe_err && !blank_ok));
  assert_clash_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err |-> (!data_oe && hv_en && !cs_n));
  assert_blank_in_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_ok |-> (hv_en && !cs_n && !data_oe));
  assert_sweep_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!data_oe && !blank_ok));
  assert_sweep_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (erase && !busy) |=> busy);
endmodule

bind eprom_prog_model eprom_prog_model_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .cs_n(cs_n), .erase(erase),
  .data_out(data_out), .data_oe(data_oe), .strobe_err(strobe_err),
  .blank_ok(blank_ok), .busy(busy)
);

// File: tb/eprom_prog_model_bench.sv
module eprom_prog_model_bench;
  localparam int PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n, hv_en, cs_n, erase;
  logic [AW-1:0] addr;
  logic [DW-1:0] data_in, data_out;
  logic data_oe, strobe_err, blank_ok, busy;
  int errors = 0;
  int checks = 0;
  int n;

  typedef struct {
    string        req;
    logic         oe;
    logic [DW-1:0] dat;
    logic         err;
    logic         blk;
    logic         bsy;
  } item_t;
  item_t sb[$];

  always #(PERIOD/2) clk = ~clk;

  eprom_prog_model #(.ADDR_W(AW), .DATA_W(DW), .LO_W(8)) u_eprom_prog_model (
    .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .cs_n(cs_n), .addr(addr),
    .data_in(data_in), .erase(erase), .data_out(data_out), .data_oe(data_oe),
    .strobe_err(strobe_err), .blank_ok(blank_ok), .busy(busy)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string req, logic oe, logic [DW-1:0] d,
                            logic err, logic blk, logic bsy);
    item_t it;
    it.req = req; it.oe = oe; it.dat = d; it.err = err; it.blk = blk; it.bsy = bsy;
    sb.push_back(it);
  endtask

  function automatic logic [AW-1:0] pa(logic sel, logic lat, logic pg, logic vf, logic [7:0] lo);
    return {sel, lat, pg, vf, lo};
  endfunction

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(it.req, "data_oe", data_oe, it.oe);
      chk(it.req, "data_out", data_out, it.dat);
      chk(it.req, "strobe_err", strobe_err, it.err);
      chk(it.req, "blank_ok", blank_ok, it.blk);
      chk(it.req, "busy", busy, it.bsy);
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; hv_en = 1'b0; cs_n = 1'b1; erase = 1'b0; addr = '0; data_in = '0;
    repeat (3) step();
    rst_n = 1'b1;
    expect_out("R2", 0, 8'h00, 0, 0, 0); step();

    erase = 1'b1; step(); erase = 1'b0;
    chk("R10", "busy after erase", busy, 1);
    n = 0;
    while (busy && n < 20000) begin step(); n++; end
    chk("R10", "sweep cycles", n, 1 << AW);

    cs_n = 1'b0; addr = 12'h123;
    expect_out("R1", 1, 8'hFF, 0, 0, 0); step();
    addr = 12'h7FF;
    expect_out("R1", 1, 8'hFF, 0, 0, 0); step();

    hv_en = 1'b1;
    addr = pa(0, 1, 1, 1, 8'h05); step();
    addr = pa(0, 0, 1, 1, 8'h3C); data_in = 8'hA5;
    expect_out("R7", 0, 8'h00, 0, 0, 0); step();
    addr = pa(0, 0, 0, 1, 8'h3C);
    expect_out("R7", 0, 8'h00, 0, 0, 0); step();
    data_in = 8'h0F; step(); step();
    addr = pa(0, 0, 1, 0, 8'h3C);
    expect_out("R5", 1, 8'hA5, 0, 0, 0); step();
    expect_out("R6", 1, 8'hA5, 0, 0, 0); step();

    addr = pa(0, 0, 1, 1, 8'h3C); data_in = 8'h3C; step();
    addr = pa(0, 0, 0, 1, 8'h3C); step();
    addr = pa(0, 0, 1, 0, 8'h3C);
    expect_out("R11", 1, 8'h24, 0, 0, 0); step();

    addr = pa(0, 0, 0, 0, 8'h3C); data_in = 8'h00;
    expect_out("R8", 0, 8'h00, 1, 0, 0); step(); step();
    addr = pa(0, 0, 1, 0, 8'h3C);
    expect_out("R8", 1, 8'h24, 0, 0, 0); step();

    addr = pa(1, 0, 1, 0, 8'h3C);
    expect_out("R9", 0, 8'h00, 0, 0, 0); step();
    addr = pa(1, 0, 1, 0, 8'h3D);
    expect_out("R9", 0, 8'h00, 0, 1, 0); step();

    hv_en = 1'b0; addr = 12'h53C;
    expect_out("R4", 1, 8'h24, 0, 0, 0); step();
    addr = 12'h03C;
    expect_out("R4", 1, 8'hFF, 0, 0, 0); step();

    hv_en = 1'b1;
    addr = pa(0, 1, 1, 1, 8'h0A); step();
    addr = pa(0, 0, 1, 1, 8'h3C); data_in = 8'h81; step();
    addr = pa(0, 0, 0, 1, 8'h3C); step();
    addr = pa(0, 0, 1, 0, 8'h3C);
    expect_out("R4", 1, 8'h81, 0, 0, 0); step();
    hv_en = 1'b0; addr = 12'hA3C;
    expect_out("R1", 1, 8'h81, 0, 0, 0); step();

    hv_en = 1'b1; cs_n = 1'b1; data_in = 8'h00;
    addr = pa(0, 0, 1, 1, 8'h3D); step();
    addr = pa(0, 0, 0, 1, 8'h3D);
    expect_out("R3", 0, 8'h00, 0, 0, 0); step(); step();
    hv_en = 1'b0; cs_n = 1'b0; addr = 12'hA3D;
    expect_out("R3", 1, 8'hFF, 0, 0, 0); step();

    erase = 1'b1; step(); erase = 1'b0;
    hv_en = 1'b1; addr = pa(0, 0, 1, 0, 8'h3C);
    expect_out("R10", 0, 8'h00, 0, 0, 1); step();
    addr = pa(0, 0, 1, 1, 8'h3C); data_in = 8'h00; step();
    addr = pa(0, 0, 0, 1, 8'h3C); step(); step();
    addr = pa(0, 0, 1, 1, 8'h3C);
    n = 0;
    while (busy && n < 20000) begin step(); n++; end
    hv_en = 1'b0; addr = 12'hA3C;
    expect_out("R10", 1, 8'hFF, 0, 0, 0); step();
    addr = 12'h53C;
    expect_out("R10", 1, 8'hFF, 0, 0, 0); step();

    cs_n = 1'b1;
    expect_out("R2", 0, 8'h00, 0, 0, 0); step();
    step();
    finish_run();
  end
endmodule